// File: doc/BRIEF.md
# I2C Slave Address-Match Receiver

This block is the receive side of an I2C slave with a programmable 7-bit own address. It takes the raw SCL and SDA lines, passes each through a two-flop synchronizer and finds clock edges, START and STOP conditions from the synchronized copies. After a START it shifts in eight bits. The first seven are compared with the own address and the eighth is kept as the read/write flag. On a hit the slave pulls SDA low during the ninth clock. On a miss it leaves SDA released, which is a NACK, and ignores the bus until the next START.

On a write address, every following data byte is acknowledged and presented on a valid/ready output. Once the transfer has happened, the byte is held with `rx_valid` high until `rx_ready` is seen high on a clock edge. The bus cannot be stalled, so there is no back-pressure on the I2C side. If a new byte completes while an earlier one has not been taken, the new byte replaces the old one in the output register and `rx_valid` stays high.

A small register port lets firmware change the own address and read a match flag and a direction bit. The match flag is set by a successful address compare. It clears by itself when the first data byte after that address has been received. On a read address the slave acknowledges the address and then leaves SDA released until the next START or STOP, because no transmit data path is present.

Top module: `i2c_own_addr_rx`

## Requirements
- R1: After reset, `sda_oe` and `rx_valid` are 0. Register 0 reads 0xA0, which is own address 0x50 in bits [7:1] with the match flag (bit 0) clear. Register 1 (status) reads 0x00.
- R2: When the seven address bits after a START equal own address bits [7:1], the slave drives SDA low (`sda_oe`=1) from the SCL fall after the eighth bit to the SCL fall after the ninth bit.
- R3: After an address match, register 0 bit 0 (match flag) reads 1.
- R4: On an address match, status bit 0 (direction) is loaded with the eighth bit received: 0 means the slave receives and 1 means the master reads.
- R5: On an address mismatch, SDA is not driven in the ninth clock and the match flag reads 0. Later bytes are neither acknowledged nor output until the next START.
- R6: After a matched write address, each data byte (MSB first) is acknowledged and output once on `rx_data` with `rx_valid`, in bus order.
- R7: The match flag clears when the first data byte after the matching address has been received.
- R8: A write to register 0 stores bits [7:1] as the new own address; bit 0 of the write is ignored. The new address is used by the next address compare.
- R9: With `rx_ready` low, `rx_valid` and `rx_data` hold steady. A newly completed byte replaces the held one.
- R10: A repeated START (no STOP in between) restarts address reception and compares the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| sda_oe | output | 1 | 1 = pull SDA low (ACK) |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = own address / match register, 1 = status register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` (combinational) |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer accepts the byte |
| rx_data | output | 8 | Received byte |

## Verification
The bench plays an open-drain master and sends several address patterns. The reset address with the write flag tells the ACK path apart from the match flag. The same address with the read flag exercises the direction bit alone. A different address checks that the slave stays silent and passes nothing on. After the own address is reprogrammed, the old address must fail and the new one must match across a repeated START. Data bytes with mixed bit patterns check MSB-first shifting and ordering. A run with the consumer held off checks that the output holds and that a later byte replaces the held one.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_DATA,
    ST_IGNORE
  } rx_state_t;

  localparam logic SEL_ADDR   = 1'b0;
  localparam logic SEL_STATUS = 1'b1;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // STAGES flops of synchronizer plus one delayed copy for edge detection
  logic [STAGES:0] scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_old;
  assign scl_now = scl_p[STAGES-1];
  assign scl_old = scl_p[STAGES];
  assign sda_s   = sda_p[STAGES-1];
  assign sda_old = sda_p[STAGES];

  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
  import i2c_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-2:0] own_addr,
  output logic              sda_oe,
  output logic              addr_done,
  output logic              addr_hit,
  output logic              addr_rw,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  rx_state_t         state;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              ack_clk_seen;
  logic              ack_then_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      shreg         <= '0;
      bit_cnt       <= '0;
      ack_clk_seen  <= 1'b0;
      ack_then_data <= 1'b0;
      sda_oe        <= 1'b0;
      addr_done     <= 1'b0;
      addr_hit      <= 1'b0;
      addr_rw       <= 1'b0;
      byte_stb      <= 1'b0;
      byte_data     <= '0;
    end else begin
      addr_done <= 1'b0;
      byte_stb  <= 1'b0;
      if (start_det) begin
        state        <= ST_ADDR;
        bit_cnt      <= '0;
        ack_clk_seen <= 1'b0;
        sda_oe       <= 1'b0;
      end else if (stop_det) begin
        state        <= ST_IDLE;
        ack_clk_seen <= 1'b0;
        sda_oe       <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_DATA: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_BIT) begin
                bit_cnt <= '0;
                if (state == ST_ADDR) begin
                  addr_done <= 1'b1;
                  addr_hit  <= (shreg[BYTE_W-2:0] == own_addr);
                  addr_rw   <= sda_s;
                  if (shreg[BYTE_W-2:0] == own_addr) begin
                    state         <= ST_ACK;
                    ack_then_data <= ~sda_s;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end else begin
                  byte_stb      <= 1'b1;
                  byte_data     <= {shreg[BYTE_W-2:0], sda_s};
                  state         <= ST_ACK;
                  ack_then_data <= 1'b1;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_rise && sda_oe) ack_clk_seen <= 1'b1;
            if (scl_fall) begin
              if (!ack_clk_seen) begin
                sda_oe <= 1'b1;
              end else begin
                sda_oe       <= 1'b0;
                ack_clk_seen <= 1'b0;
                state        <= ack_then_data ? ST_DATA : ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the ACK drive only begins on an SCL falling edge
  a_r2_ack_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
  // R6: a data byte completes only on an SCL rising edge
  a_r6_byte_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> $past(scl_rise));
  // R5: a missed address is never acknowledged
  a_r5_no_ack_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_hit) |=> !sda_oe);
endmodule

// File: rtl/i2c_slv_regs.sv
module i2c_slv_regs
  import i2c_rx_pkg::*;
#(
  parameter int          BYTE_W     = 8,
  parameter logic [7:0]  RESET_ADDR = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              addr_done,
  input  logic              addr_hit,
  input  logic              addr_rw,
  input  logic              byte_stb,
  output logic [BYTE_W-2:0] own_addr,
  output logic [BYTE_W-1:0] reg_rdata
);
  logic match_flag;
  logic dir_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_addr   <= RESET_ADDR[BYTE_W-1:1];
      match_flag <= 1'b0;
      dir_bit    <= 1'b0;
    end else begin
      if (reg_we && reg_sel == SEL_ADDR) own_addr <= reg_wdata[BYTE_W-1:1];
      if (addr_done) begin
        match_flag <= addr_hit;
        if (addr_hit) dir_bit <= addr_rw;
      end else if (byte_stb) begin
        match_flag <= 1'b0;
      end
    end
  end

  always_comb begin
    if (reg_sel == SEL_STATUS) reg_rdata = {{(BYTE_W-1){1'b0}}, dir_bit};
    else                       reg_rdata = {own_addr, match_flag};
  end

  // R7: the first data byte clears the match flag
  a_r7_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !match_flag);
  // R4: direction follows the R/W bit of a matched address
  a_r4_dir_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && addr_hit) |=> (dir_bit == $past(addr_rw)));
endmodule

// File: rtl/i2c_own_addr_rx.sv
module i2c_own_addr_rx #(
  parameter int         BYTE_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] RESET_ADDR  = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic addr_done, addr_hit, addr_rw, byte_stb;
  logic [BYTE_W-1:0] byte_data;
  logic [BYTE_W-2:0] own_addr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rx_fsm #(.BYTE_W(BYTE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .sda_oe(sda_oe), .addr_done(addr_done),
    .addr_hit(addr_hit), .addr_rw(addr_rw), .byte_stb(byte_stb),
    .byte_data(byte_data)
  );

  i2c_slv_regs #(.BYTE_W(BYTE_W), .RESET_ADDR(RESET_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .addr_done(addr_done), .addr_hit(addr_hit),
    .addr_rw(addr_rw), .byte_stb(byte_stb), .own_addr(own_addr),
    .reg_rdata(reg_rdata)
  );

  // output holding register: a new byte always wins over an untaken one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (byte_stb) begin
      rx_valid <= 1'b1;
      rx_data  <= byte_data;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  // R9: an untaken byte holds while no newer byte arrives
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !byte_stb) |=> (rx_valid && $stable(rx_data)));
endmodule

// File: tb/i2c_own_addr_rx_bench.sv
module i2c_own_addr_rx_bench;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata, rx_data;
  logic rx_valid, rx_ready = 1'b1;
  logic line_sda;

  assign line_sda = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_own_addr_rx u_i2c_own_addr_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line_sda),
    .sda_oe(sda_oe), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data)
  );

  int n_vec = 0, n_bad = 0;
  logic [7:0] exp_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    wt(4); sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wt(4); sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      wt(4); sda_m = b[i]; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0;
    end
    wt(4); sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2);
    acked = (line_sda == 1'b0);
    wt(H/2); scl_m = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output logic [7:0] v);
    @(negedge clk); reg_sel = sel; #1; v = reg_rdata;
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5/R6 unexpected byte", rx_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rx_data == e, "R6 data order", rx_data, e);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    bit ak;
    logic [7:0] v;
    wt(5); rst_n = 1'b1; wt(3);
    // R1 reset state
    check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    rd_reg(1'b0, v); check(v == 8'hA0, "R1 addr reg", v, 8'hA0);
    rd_reg(1'b1, v); check(v == 8'h00, "R1 status", v, 0);

    // matched write address then data
    bus_start();
    send_byte(8'hA0, ak); check(ak, "R2 ack on match", ak, 1);
    rd_reg(1'b0, v); check(v == 8'hA1, "R3 match flag", v, 8'hA1);
    rd_reg(1'b1, v); check(v == 8'h00, "R4 dir write", v, 0);
    exp_q.push_back(8'h11); send_byte(8'h11, ak); check(ak, "R6 data ack", ak, 1);
    rd_reg(1'b0, v); check(v == 8'hA0, "R7 match cleared", v, 8'hA0);
    exp_q.push_back(8'h22); send_byte(8'h22, ak); check(ak, "R6 data ack", ak, 1);
    exp_q.push_back(8'hE7); send_byte(8'hE7, ak); check(ak, "R6 data ack", ak, 1);
    bus_stop();
    check(exp_q.size() == 0, "R6 all delivered", exp_q.size(), 0);

    // matched read address
    bus_start();
    send_byte(8'hA1, ak); check(ak, "R2 ack read addr", ak, 1);
    rd_reg(1'b1, v); check(v == 8'h01, "R4 dir read", v, 1);
    bus_stop();

    // mismatch
    bus_start();
    send_byte(8'h42, ak); check(!ak, "R5 nack on miss", ak, 0);
    rd_reg(1'b0, v); check(v == 8'hA0, "R5 match clear", v, 8'hA0);
    send_byte(8'h77, ak); check(!ak, "R5 data ignored", ak, 0);
    wt(10); check(rx_valid == 1'b0, "R5 no output", rx_valid, 0);
    bus_stop();

    // reprogram address, repeated start
    @(negedge clk); reg_sel = 1'b0; reg_wdata = 8'h5B; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    rd_reg(1'b0, v); check(v == 8'h5A, "R8 addr write", v, 8'h5A);
    bus_start();
    send_byte(8'hA0, ak); check(!ak, "R8 old addr misses", ak, 0);
    bus_start();
    send_byte(8'h5A, ak); check(ak, "R10 repeated start match", ak, 1);
    exp_q.push_back(8'h99); send_byte(8'h99, ak); check(ak, "R10 data ack", ak, 1);
    bus_stop();
    check(exp_q.size() == 0, "R10 delivered", exp_q.size(), 0);

    // back-pressure: hold then replace
    rx_ready = 1'b0;
    bus_start();
    send_byte(8'h5A, ak); check(ak, "R9 addr ack", ak, 1);
    send_byte(8'h3C, ak);
    wt(50);
    check(rx_valid == 1'b1, "R9 valid held", rx_valid, 1);
    check(rx_data == 8'h3C, "R9 data held", rx_data, 8'h3C);
    send_byte(8'h4D, ak);
    wt(10);
    check(rx_data == 8'h4D, "R9 replaced", rx_data, 8'h4D);
    bus_stop();
    exp_q.push_back(8'h4D);
    @(negedge clk); rx_ready = 1'b1;
    wt(3);
    check(rx_valid == 1'b0, "R9 taken", rx_valid, 0);
    check(exp_q.size() == 0, "R9 delivered once", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule